// File: doc/BRIEF.md
# Float to Integer Saturating Converter

This block turns an unpacked floating-point operand into a 32-bit signed two's-complement integer in one registered stage. The operand comes in already unpacked: a class code, a sign, an unbiased signed exponent, a normalized mantissa whose top bit is the leading one, and a sticky bit that stands for any bits dropped further upstream. A 2-bit rounding-mode input picks how a fractional value is resolved, and a truncate input forces round-toward-zero whatever the mode says.

Results that do not fit in the integer range, infinities and NaNs saturate to the largest positive or the most negative integer and raise an invalid-conversion flag. The limits differ by sign, so -2^31 converts exactly while +2^31 saturates. Any NaN saturates to the negative limit. The rounding status flags are reported only when the conversion succeeds. A signalling NaN raises its own invalid flag as well.

The block sits in a floating-point pipeline. Every operand marked by valid_i produces a result and flags marked by valid_o one clock later.

Top module: `f2i_conv`

## Requirements
- R1: A zero-class operand (class code 0) yields result 0 with every flag clear.
- R2: A normal operand (class code 1) whose value is an integer in range converts exactly, with negative values as two's complement, and raises no flags.
- R3: With rounding-mode 00 (nearest, ties to even) the magnitude is incremented when the guard bit (first bit below the integer LSB) is set and either the OR of all lower bits and sticky_i, or the integer LSB, is 1.
- R4: Rounding-mode 01 (toward zero) never increments. Asserting trunc_i selects toward-zero for any rmode_i value.
- R5: Rounding-mode 10 (toward +inf) increments only positive inexact operands. Rounding-mode 11 (toward -inf) increments only negative inexact operands.
- R6: An inexact in-range conversion sets inexact_o and frac_inexact_o. One that was incremented also sets frac_round_o.
- R7: A normal operand with exponent 32 or more, or whose rounded magnitude is at least 0x80000000 plus the sign, gives 0x7FFFFFFF when positive and 0x80000000 when negative. It sets cvt_inv_o and clears inexact_o, frac_inexact_o and frac_round_o.
- R8: A quiet NaN (class code 3) or signalling NaN (class code 4) gives 0x80000000 with cvt_inv_o, whatever its sign. Only the signalling NaN also sets snan_inv_o.
- R9: An infinity (class code 2) saturates by sign exactly as in R7.
- R10: A negative exponent leaves an integer part of 0, and rounding alone decides between 0 and 1 in magnitude.
- R11: valid_o follows valid_i by one clock. While valid_o is low, result_o and all flags are 0, and reset clears them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand valid |
| cls_i | input | 3 | Class: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| sign_i | input | 1 | Operand sign, 1 = negative |
| exp_i | input | EXP_W (12) | Unbiased exponent, two's complement |
| mant_i | input | MANT_W (24) | Mantissa, MSB is the leading one |
| sticky_i | input | 1 | OR of bits dropped below the mantissa |
| rmode_i | input | 2 | Rounding mode: 00 nearest-even, 01 zero, 10 +inf, 11 -inf |
| trunc_i | input | 1 | Force round toward zero |
| valid_o | output | 1 | Result valid |
| result_o | output | INT_W (32) | Signed integer result |
| inexact_o | output | 1 | Result was inexact |
| frac_inexact_o | output | 1 | Fraction inexact |
| frac_round_o | output | 1 | Magnitude was incremented |
| snan_inv_o | output | 1 | Signalling NaN operand |
| cvt_inv_o | output | 1 | Invalid conversion (saturated) |

## Verification
All state lives in the output register. A wrong round decision or a wrong saturation choice shows at result_o and the flags in the very cycle valid_o rises, one clock after the operand. The decisive cases sit at edges: ties with even and odd LSBs, magnitudes 2^31 with and without a carry from rounding, negative exponents of -1 and below, and the sign-dependent limits. The vector set is built around those edges. Flag suppression on overflow and idle zeroing of the outputs are also checked on every cycle by properties on the ports.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } f2i_cls_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } f2i_rm_e;

  typedef struct packed {
    logic inexact;
    logic frac_inexact;
    logic frac_round;
    logic snan_inv;
    logic cvt_inv;
  } f2i_flags_t;
endpackage

// File: rtl/f2i_align.sv
// Places the mantissa against the integer LSB and extracts guard / rest.
module f2i_align #(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 12,
  parameter int INT_W  = 32
) (
  input  logic signed [EXP_W-1:0]  exp_i,
  input  logic        [MANT_W-1:0] mant_i,
  input  logic                     sticky_i,
  output logic        [INT_W-1:0]  mag_o,
  output logic                     guard_o,
  output logic                     rest_o,
  output logic                     too_big_o
);
  localparam int WIDE_W = INT_W + MANT_W;
  localparam int SH_W   = $clog2(INT_W + 1);
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);
  localparam logic signed [EXP_W-1:0] EXP_M1  = '1;

  logic [WIDE_W-1:0] wide;
  logic [SH_W-1:0]   sh;

  always_comb begin
    too_big_o = (exp_i >= EXP_LIM);
    sh        = exp_i[SH_W-1:0] + SH_W'(1);
    wide      = '0;
    mag_o     = '0;
    guard_o   = 1'b0;
    rest_o    = 1'b0;
    if (exp_i < 0) begin
      // whole mantissa lies below the integer LSB
      if (exp_i == EXP_M1) begin
        guard_o = mant_i[MANT_W-1];
        rest_o  = (|mant_i[MANT_W-2:0]) | sticky_i;
      end else begin
        rest_o  = (|mant_i) | sticky_i;
      end
    end else if (!too_big_o) begin
      wide    = {{INT_W{1'b0}}, mant_i} << sh;
      mag_o   = wide[WIDE_W-1:MANT_W];
      guard_o = wide[MANT_W-1];
      rest_o  = (|wide[MANT_W-2:0]) | sticky_i;
    end
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] mag_i,
  input  logic             guard_i,
  input  logic             rest_i,
  input  logic             sign_i,
  input  f2i_rm_e          rm_i,
  output logic [INT_W:0]   mag_o,
  output logic             inexact_o,
  output logic             incr_o
);
  always_comb begin
    inexact_o = guard_i | rest_i;
    unique case (rm_i)
      RM_NEAR: incr_o = guard_i & (rest_i | mag_i[0]);
      RM_ZERO: incr_o = 1'b0;
      RM_UP:   incr_o = inexact_o & ~sign_i;
      RM_DOWN: incr_o = inexact_o & sign_i;
      default: incr_o = 1'b0;
    endcase
    mag_o = {1'b0, mag_i} + (INT_W+1)'(incr_o);
  end
endmodule

// File: rtl/f2i_sat.sv
// Range check, saturation by class and sign, flag commit.
module f2i_sat
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  f2i_cls_e         cls_i,
  input  logic             sign_i,
  input  logic             too_big_i,
  input  logic [INT_W:0]   rmag_i,
  input  logic             inexact_i,
  input  logic             incr_i,
  output logic [INT_W-1:0] result_o,
  output f2i_flags_t       flags_o
);
  localparam logic [INT_W:0]   HALF    = (INT_W+1)'(1) << (INT_W-1);
  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic [INT_W:0] limit;
  logic           ovf;
  logic           sat;
  logic           sat_neg;

  always_comb begin
    limit    = HALF + (INT_W+1)'(sign_i);
    ovf      = too_big_i || (rmag_i >= limit);
    sat      = 1'b0;
    sat_neg  = sign_i;
    result_o = '0;
    flags_o  = '0;
    unique case (cls_i)
      CLS_ZERO: ;
      CLS_NUM: begin
        if (ovf) begin
          sat = 1'b1;
        end else begin
          result_o             = sign_i ? (~rmag_i[INT_W-1:0] + INT_W'(1))
                                        : rmag_i[INT_W-1:0];
          flags_o.inexact      = inexact_i;
          flags_o.frac_inexact = inexact_i;
          flags_o.frac_round   = incr_i;
        end
      end
      CLS_INF: sat = 1'b1;
      CLS_SNAN: begin
        sat              = 1'b1;
        sat_neg          = 1'b1;
        flags_o.snan_inv = 1'b1;
      end
      default: begin
        sat     = 1'b1;
        sat_neg = 1'b1;
      end
    endcase
    if (sat) begin
      result_o        = sat_neg ? NEG_MIN : POS_MAX;
      flags_o.cvt_inv = 1'b1;
    end
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 12,
  parameter int INT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        cls_i,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic [1:0]        rmode_i,
  input  logic              trunc_i,
  output logic              valid_o,
  output logic [INT_W-1:0]  result_o,
  output logic              inexact_o,
  output logic              frac_inexact_o,
  output logic              frac_round_o,
  output logic              snan_inv_o,
  output logic              cvt_inv_o
);
  f2i_rm_e          rm_eff;
  logic [INT_W-1:0] a_mag;
  logic             a_guard, a_rest, a_big;
  logic [INT_W:0]   r_mag;
  logic             r_inexact, r_incr;
  logic [INT_W-1:0] s_result;
  f2i_flags_t       s_flags;
  f2i_flags_t       flags_q;

  assign rm_eff = trunc_i ? RM_ZERO : f2i_rm_e'(rmode_i);

  f2i_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) i_align (
    .exp_i    ($signed(exp_i)),
    .mant_i   (mant_i),
    .sticky_i (sticky_i),
    .mag_o    (a_mag),
    .guard_o  (a_guard),
    .rest_o   (a_rest),
    .too_big_o(a_big)
  );

  f2i_round #(.INT_W(INT_W)) i_round (
    .mag_i    (a_mag),
    .guard_i  (a_guard),
    .rest_i   (a_rest),
    .sign_i   (sign_i),
    .rm_i     (rm_eff),
    .mag_o    (r_mag),
    .inexact_o(r_inexact),
    .incr_o   (r_incr)
  );

  f2i_sat #(.INT_W(INT_W)) i_sat (
    .cls_i    (f2i_cls_e'(cls_i)),
    .sign_i   (sign_i),
    .too_big_i(a_big),
    .rmag_i   (r_mag),
    .inexact_i(r_inexact),
    .incr_i   (r_incr),
    .result_o (s_result),
    .flags_o  (s_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_q  <= '0;
    end else begin
      valid_o  <= valid_i;
      result_o <= valid_i ? s_result : '0;
      flags_q  <= valid_i ? s_flags : '0;
    end
  end

  assign inexact_o      = flags_q.inexact;
  assign frac_inexact_o = flags_q.frac_inexact;
  assign frac_round_o   = flags_q.frac_round;
  assign snan_inv_o     = flags_q.snan_inv;
  assign cvt_inv_o      = flags_q.cvt_inv;
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int INT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       cls_i,
  input logic             valid_o,
  input logic [INT_W-1:0] result_o,
  input logic             inexact_o,
  input logic             frac_inexact_o,
  input logic             frac_round_o,
  input logic             snan_inv_o,
  input logic             cvt_inv_o
);
  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

  assert_valid_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0) && !inexact_o && !frac_inexact_o
                 && !frac_round_o && !snan_inv_o && !cvt_inv_o);
  assert_zero_class_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == 3'd0) |=> (result_o == '0) && !inexact_o
                                   && !frac_round_o && !cvt_inv_o && !snan_inv_o);
  assert_inexact_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (inexact_o == frac_inexact_o) && (!frac_round_o || inexact_o));
  assert_no_round_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cvt_inv_o |-> !inexact_o && !frac_inexact_o && !frac_round_o);
  assert_sat_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cvt_inv_o |-> (result_o == POS_MAX) || (result_o == NEG_MIN));
  assert_snan_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snan_inv_o |-> cvt_inv_o && (result_o == NEG_MIN));
endmodule

bind f2i_conv f2i_conv_chk #(.INT_W(INT_W)) i_f2i_conv_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .cls_i         (cls_i),
  .valid_o       (valid_o),
  .result_o      (result_o),
  .inexact_o     (inexact_o),
  .frac_inexact_o(frac_inexact_o),
  .frac_round_o  (frac_round_o),
  .snan_inv_o    (snan_inv_o),
  .cvt_inv_o     (cvt_inv_o)
);

// File: tb/test_f2i_conv.sv
`timescale 1ns/1ps
module test_f2i_conv;
  localparam int MANT_W = 24;
  localparam int EXP_W  = 12;
  localparam int INT_W  = 32;

  // flags packing (bench only): {inexact, frac_inexact, frac_round, snan_inv, cvt_inv}
  typedef struct packed {
    logic [2:0]        cls;
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [MANT_W-1:0] mant;
    logic              sticky;
    logic [1:0]        rm;
    logic              trunc;
    logic [INT_W-1:0]  res;
    logic [4:0]        flg;
    logic [3:0]        req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 12'd0,   24'h000000, 1'b0, 2'd0, 1'b0, 32'h00000000, 5'b00000, 4'd1},  // R1
    '{3'd1, 1'b0, 12'd2,   24'hA00000, 1'b0, 2'd0, 1'b0, 32'h00000005, 5'b00000, 4'd2},  // R2 5.0
    '{3'd1, 1'b1, 12'd2,   24'hA00000, 1'b0, 2'd0, 1'b0, 32'hFFFFFFFB, 5'b00000, 4'd2},  // R2 -5.0
    '{3'd1, 1'b0, 12'd30,  24'hFFFFFF, 1'b0, 2'd0, 1'b0, 32'h7FFFFF80, 5'b00000, 4'd2},  // R2 large
    '{3'd1, 1'b1, 12'd30,  24'hFFFFFF, 1'b0, 2'd0, 1'b0, 32'h80000080, 5'b00000, 4'd2},  // R2 large neg
    '{3'd1, 1'b0, 12'd1,   24'hA00000, 1'b0, 2'd0, 1'b0, 32'h00000002, 5'b11000, 4'd3},  // R3 2.5 tie even
    '{3'd1, 1'b0, 12'd1,   24'hE00000, 1'b0, 2'd0, 1'b0, 32'h00000004, 5'b11100, 4'd3},  // R3 3.5 tie odd
    '{3'd1, 1'b0, 12'd1,   24'hA00000, 1'b1, 2'd0, 1'b0, 32'h00000003, 5'b11100, 4'd3},  // R3 sticky breaks tie
    '{3'd1, 1'b1, 12'd1,   24'hB00000, 1'b0, 2'd0, 1'b0, 32'hFFFFFFFD, 5'b11100, 4'd3},  // R3 -2.75
    '{3'd1, 1'b0, 12'd1,   24'h900000, 1'b0, 2'd0, 1'b0, 32'h00000002, 5'b11000, 4'd3},  // R3 2.25
    '{3'd1, 1'b0, 12'd1,   24'hB00000, 1'b0, 2'd1, 1'b0, 32'h00000002, 5'b11000, 4'd4},  // R4 zero mode
    '{3'd1, 1'b0, 12'd1,   24'hB00000, 1'b0, 2'd0, 1'b1, 32'h00000002, 5'b11000, 4'd4},  // R4 trunc over nearest
    '{3'd1, 1'b1, 12'd1,   24'hB00000, 1'b0, 2'd3, 1'b1, 32'hFFFFFFFE, 5'b11000, 4'd4},  // R4 trunc over -inf
    '{3'd1, 1'b0, 12'd1,   24'h900000, 1'b0, 2'd2, 1'b0, 32'h00000003, 5'b11100, 4'd5},  // R5 +inf pos
    '{3'd1, 1'b1, 12'd1,   24'h900000, 1'b0, 2'd2, 1'b0, 32'hFFFFFFFE, 5'b11000, 4'd5},  // R5 +inf neg
    '{3'd1, 1'b1, 12'd1,   24'h900000, 1'b0, 2'd3, 1'b0, 32'hFFFFFFFD, 5'b11100, 4'd5},  // R5 -inf neg
    '{3'd1, 1'b0, 12'd1,   24'h900000, 1'b0, 2'd3, 1'b0, 32'h00000002, 5'b11000, 4'd5},  // R5 -inf pos
    '{3'd1, 1'b0, 12'd30,  24'hFFFFFF, 1'b1, 2'd2, 1'b0, 32'h7FFFFF81, 5'b11100, 4'd6},  // R6 sticky only
    '{3'd1, 1'b0, 12'hFFF, 24'hC00000, 1'b0, 2'd0, 1'b0, 32'h00000001, 5'b11100, 4'd10}, // R10 0.75
    '{3'd1, 1'b0, 12'hFFE, 24'h800000, 1'b0, 2'd0, 1'b0, 32'h00000000, 5'b11000, 4'd10}, // R10 0.25
    '{3'd1, 1'b0, 12'hFFE, 24'h800000, 1'b0, 2'd2, 1'b0, 32'h00000001, 5'b11100, 4'd10}, // R10 0.25 up
    '{3'd1, 1'b0, 12'hFFF, 24'h800000, 1'b0, 2'd0, 1'b0, 32'h00000000, 5'b11000, 4'd10}, // R10 0.5 tie
    '{3'd1, 1'b1, 12'hF00, 24'h800000, 1'b0, 2'd3, 1'b0, 32'hFFFFFFFF, 5'b11100, 4'd10}, // R10 tiny neg down
    '{3'd1, 1'b0, 12'd31,  24'h800000, 1'b0, 2'd0, 1'b0, 32'h7FFFFFFF, 5'b00001, 4'd7},  // R7 +2^31
    '{3'd1, 1'b1, 12'd31,  24'h800000, 1'b0, 2'd0, 1'b0, 32'h80000000, 5'b00000, 4'd7},  // R7 -2^31 fits
    '{3'd1, 1'b1, 12'd31,  24'h800000, 1'b1, 2'd3, 1'b0, 32'h80000000, 5'b00001, 4'd7},  // R7 round carries over
    '{3'd1, 1'b0, 12'd32,  24'h800000, 1'b0, 2'd1, 1'b0, 32'h7FFFFFFF, 5'b00001, 4'd7},  // R7 exp 32
    '{3'd1, 1'b0, 12'd31,  24'h800000, 1'b1, 2'd1, 1'b0, 32'h7FFFFFFF, 5'b00001, 4'd7}   // R7 inexact suppressed
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [2:0]        cls_i = '0;
  logic              sign_i = 1'b0;
  logic [EXP_W-1:0]  exp_i = '0;
  logic [MANT_W-1:0] mant_i = '0;
  logic              sticky_i = 1'b0;
  logic [1:0]        rmode_i = '0;
  logic              trunc_i = 1'b0;
  logic              valid_o;
  logic [INT_W-1:0]  result_o;
  logic              inexact_o, frac_inexact_o, frac_round_o, snan_inv_o, cvt_inv_o;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk_i = ~clk_i;

  f2i_conv #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) i_f2i_conv (
    .clk_i, .rst_ni, .valid_i, .cls_i, .sign_i, .exp_i, .mant_i, .sticky_i,
    .rmode_i, .trunc_i, .valid_o, .result_o, .inexact_o, .frac_inexact_o,
    .frac_round_o, .snan_inv_o, .cvt_inv_o
  );

  function automatic logic [4:0] flags_now();
    return {inexact_o, frac_inexact_o, frac_round_o, snan_inv_o, cvt_inv_o};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] c, input logic s, input logic [EXP_W-1:0] e,
                       input logic [MANT_W-1:0] m, input logic st, input logic [1:0] rm,
                       input logic tr);
    cls_i = c; sign_i = s; exp_i = e; mant_i = m; sticky_i = st;
    rmode_i = rm; trunc_i = tr; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11 reset valid", 64'(valid_o), 64'd0);
    check("R11 reset result", 64'(result_o), 64'd0);
    check("R11 reset flags", 64'(flags_now()), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].cls, VECS[i].sign, VECS[i].exp, VECS[i].mant,
            VECS[i].sticky, VECS[i].rm, VECS[i].trunc);
      check($sformatf("R%0d vec %0d valid", VECS[i].req, i), 64'(valid_o), 64'd1);
      check($sformatf("R%0d vec %0d result", VECS[i].req, i), 64'(result_o), 64'(VECS[i].res));
      check($sformatf("R%0d vec %0d flags", VECS[i].req, i), 64'(flags_now()), 64'(VECS[i].flg));
    end

    // R9 infinities
    apply(3'd2, 1'b0, 12'd0, 24'h800000, 1'b0, 2'd0, 1'b0);
    check("R9 +inf result", 64'(result_o), 64'h7FFFFFFF);
    check("R9 +inf flags", 64'(flags_now()), 64'b00001);
    apply(3'd2, 1'b1, 12'd0, 24'h800000, 1'b0, 2'd1, 1'b0);
    check("R9 -inf result", 64'(result_o), 64'h80000000);
    check("R9 -inf flags", 64'(flags_now()), 64'b00001);

    // R8 NaNs, positive sign still goes negative
    apply(3'd3, 1'b0, 12'd5, 24'hC00000, 1'b0, 2'd0, 1'b0);
    check("R8 qnan result", 64'(result_o), 64'h80000000);
    check("R8 qnan flags", 64'(flags_now()), 64'b00001);
    apply(3'd4, 1'b0, 12'd5, 24'hC00000, 1'b1, 2'd2, 1'b0);
    check("R8 snan result", 64'(result_o), 64'h80000000);
    check("R8 snan flags", 64'(flags_now()), 64'b00011);

    // R11 idle cycle zeroes outputs, back-to-back operands
    @(negedge clk_i);
    check("R11 idle valid", 64'(valid_o), 64'd0);
    check("R11 idle result", 64'(result_o), 64'd0);
    check("R11 idle flags", 64'(flags_now()), 64'd0);
    cls_i = 3'd1; sign_i = 1'b0; exp_i = 12'd2; mant_i = 24'hE00000;
    sticky_i = 1'b0; rmode_i = 2'd0; trunc_i = 1'b0; valid_i = 1'b1;
    @(negedge clk_i);
    check("R11 b2b first", 64'(result_o), 64'd7);
    exp_i = 12'd3;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R11 b2b second", 64'(result_o), 64'd14);
    @(negedge clk_i);
    check("R11 b2b drop", 64'(valid_o), 64'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule